// File: doc/BRIEF.md
# Rate-Configurable TDM Serial Port Group

This block sits between four local serial TDM pins and a byte-wide time-slot interface. The four pins always carry 128 byte slots per frame in each direction, but the group can be arranged three ways: four streams, one per pin, at the slowest bit rate; two streams on pins 0 and 1 at twice that rate; or a single stream on pin 0 at four times the rate. The receive and transmit directions each take their own layout setting. Each setting takes effect only when a frame begins.

One clock runs at the fastest bit rate, and a frame lasts FRAME_SLOTS×8 clocks. Slower layouts hold each bit for two or four clocks. On receive, the block samples each live pin on the last clock of a bit and assembles the bits most significant first. At the end of a slot, all live streams finish their bytes together. The block then hands those bytes out one per clock, each tagged with its stream and slot. On transmit, the block asks for one slot at a time and takes one byte per lane, then shifts the bytes out most significant bit first. Output enables mark which pins are live.

Top module: `tdm_port_group`

## Requirements
- R1: Frame position is 0 in the clock where `frame_start` is high and rises by one each clock after that. Without a new strobe it returns to 0 after FRAME_SLOTS×8−1 (1023 by default).
- R2: Layout codes: 0 gives four streams on pins 0..3 with 4 clocks per bit. 1 gives two streams on pins 0..1 with 2 clocks per bit. 2 gives one stream on pin 0 with 1 clock per bit. Code 3 behaves as code 2. With D clocks per bit, one slot spans 8·D clocks.
- R3: Receive bit k of slot s (k=0 is the MSB) is taken from the stream's pin at frame position (8s+k)·D + D−1.
- R4: The bytes of slot s finish at position 8D(s+1)−1. In the following clocks, `rx_valid` is high once per live stream, in ascending stream order, one clock each, with `rx_slot`=s and `rx_byte` holding the assembled byte.
- R5: Values on pins that are not live in the current receive layout do not affect any received byte.
- R6: Each direction's layout is taken from its mode input only in a clock with `frame_start` high. Changes between strobes have no effect, and the two directions are independent.
- R7: `tx_fetch` is high for exactly one clock at each slot start (position 8D·s) with `tx_slot`=s. In that clock, lane i of `tx_data` (bits 8i+7..8i) is read as stream i's byte.
- R8: Bit k (MSB first) of a fetched byte is on `tx_pin[i]` from the clock after position (8s+k)·D through the clock after position (8s+k+1)·D−1. That is a one-clock lag behind the frame position.
- R9: `tx_oe[i]` is high exactly for the pins that are live in the transmit layout, with the same one-clock lag as the data.
- R10: After reset and before the first `frame_start`, `rx_valid`, `tx_fetch` and all of `tx_oe` stay low.
- R11: Bytes that finish in the last slot of a frame are still handed out after the next frame start, even when that start switches the receive layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the highest bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-clock strobe marking frame position 0 |
| rx_mode | input | MODE_W | Receive layout code, latched at frame start |
| tx_mode | input | MODE_W | Transmit layout code, latched at frame start |
| rx_pin | input | NUM_PINS | Serial receive pins |
| rx_valid | output | 1 | A received byte is presented |
| rx_byte | output | 8 | Received byte |
| rx_stream | output | STRM_W | Stream index of the received byte |
| rx_slot | output | SLOT_W | Slot index of the received byte |
| tx_fetch | output | 1 | Request for the bytes of `tx_slot` |
| tx_slot | output | SLOT_W | Slot index being requested |
| tx_data | input | NUM_PINS*8 | One byte per lane for the requested slot |
| tx_pin | output | NUM_PINS | Serial transmit pins |
| tx_oe | output | NUM_PINS | Drive enable per transmit pin |

## Verification
Two things collide at a frame start. The receive hand-out of the previous frame's last slot is still running when the new frame's layout is latched and its first bit is sampled. The bench provokes this by switching the receive layout at every strobe: four-stream into two-stream, two-stream into one-stream, and one-stream back into four-stream. It expects the tail bytes to keep the stream count, tags and contents of the old layout while the new frame's slots follow the new one. On the transmit side, the fetch at slot 0 falls in the same clock as the last bit of the previous frame on the pins. Both are checked in that clock.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;

  // log2 of clocks per bit for a layout code; codes beyond the widest clamp
  function automatic int rate_shift(int mode, int pin_lg);
    int m;
    m = (mode > pin_lg) ? pin_lg : mode;
    return pin_lg - m;
  endfunction

  // live streams equal clocks per bit: capacity is constant
  function automatic int stream_count(int mode, int pin_lg);
    return 1 << rate_shift(mode, pin_lg);
  endfunction

  function automatic int slot_of(int pos, int shft);
    return pos >> (shft + 3);
  endfunction

  function automatic int bit_of(int pos, int shft);
    return (pos >> shft) & 7;
  endfunction

  function automatic int phase_of(int pos, int shft);
    return pos & ((1 << shft) - 1);
  endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
`timescale 1ns/1ps
module tdm_frame_timer #(
  parameter int FRAME_CLKS = 1024,
  localparam int POS_W = $clog2(FRAME_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  output logic [POS_W-1:0] pos,
  output logic             go
);
  logic [POS_W-1:0] pos_q;
  logic             run_q;

  assign pos = frame_start ? '0 : pos_q;
  assign go  = frame_start | run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (frame_start) run_q <= 1'b1;
      pos_q <= (pos == POS_W'(FRAME_CLKS - 1)) ? '0 : pos + 1'b1;
    end
  end

  // R1: strobe restarts the count
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pos_q == POS_W'(1)));
  // R1: free-running wrap at the frame length
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == POS_W'(FRAME_CLKS - 1)) |=> (pos == '0));
endmodule

// File: rtl/tdm_mode_latch.sv
`timescale 1ns/1ps
module tdm_mode_latch #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_act
);
  logic [MODE_W-1:0] mode_q;

  // the new layout already governs the strobe clock itself
  assign mode_act = frame_start ? mode_in : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= '0;
    else if (frame_start) mode_q <= mode_in;
  end

  // R6: layout frozen between strobes
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (frame_start || $stable(mode_act)));
endmodule

// File: rtl/tdm_rx_path.sv
`timescale 1ns/1ps
module tdm_rx_path
  import tdm_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int POS_W    = 10,
  parameter int SLOT_W   = 7,
  parameter int STRM_W   = 2,
  parameter int MODE_W   = 2,
  parameter int PIN_LG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [POS_W-1:0]  pos,
  input  logic [MODE_W-1:0] mode,
  input  logic [NUM_PINS-1:0] rx_pin,
  output logic              rx_valid,
  output logic [7:0]        rx_byte,
  output logic [STRM_W-1:0] rx_stream,
  output logic [SLOT_W-1:0] rx_slot
);
  int                 shv;
  logic               sample;
  logic               byte_done;
  logic [NUM_PINS-1:0] live;
  logic [NUM_PINS-1:0] pend_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [STRM_W-1:0]  idx;
  logic [6:0]         shr_q  [NUM_PINS];
  logic [7:0]         hold_q [NUM_PINS];

  always_comb begin
    shv       = rate_shift(int'(mode), PIN_LG);
    sample    = go && (phase_of(int'(pos), shv) == ((1 << shv) - 1));
    byte_done = sample && (bit_of(int'(pos), shv) == 7);
    for (int i = 0; i < NUM_PINS; i++)
      live[i] = (i < stream_count(int'(mode), PIN_LG));
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shr_q[g]  <= '0;
        hold_q[g] <= '0;
      end else if (sample && live[g]) begin
        shr_q[g] <= {shr_q[g][5:0], rx_pin[g]};
        if (byte_done) hold_q[g] <= {shr_q[g], rx_pin[g]};
      end
    end
  end

  // lowest pending lane goes out first
  always_comb begin
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (pend_q[i]) idx = STRM_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      slot_q <= '0;
    end else if (byte_done) begin
      pend_q <= live;
      slot_q <= SLOT_W'(slot_of(int'(pos), shv));
    end else if (rx_valid) begin
      pend_q[idx] <= 1'b0;
    end
  end

  assign rx_valid  = |pend_q;
  assign rx_stream = idx;
  assign rx_byte   = hold_q[idx];
  assign rx_slot   = slot_q;

  // R4: previous slot fully handed out before the next completes
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (pend_q == '0));
  // R4: back-to-back hand-out climbs by one stream
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(rx_valid)) |-> (rx_stream == $past(rx_stream) + 1'b1));
endmodule

// File: rtl/tdm_tx_path.sv
`timescale 1ns/1ps
module tdm_tx_path
  import tdm_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int POS_W    = 10,
  parameter int SLOT_W   = 7,
  parameter int MODE_W   = 2,
  parameter int PIN_LG   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [POS_W-1:0]      pos,
  input  logic [MODE_W-1:0]     mode,
  input  logic [NUM_PINS*8-1:0] tx_data,
  output logic                  tx_fetch,
  output logic [SLOT_W-1:0]     tx_slot,
  output logic [NUM_PINS-1:0]   tx_pin,
  output logic [NUM_PINS-1:0]   tx_oe
);
  int                  shv;
  logic                bit_start;
  logic                slot_start;
  logic [NUM_PINS-1:0] live;
  logic [6:0]          sr_q [NUM_PINS];

  always_comb begin
    shv        = rate_shift(int'(mode), PIN_LG);
    bit_start  = go && (phase_of(int'(pos), shv) == 0);
    slot_start = bit_start && (bit_of(int'(pos), shv) == 0);
    for (int i = 0; i < NUM_PINS; i++)
      live[i] = (i < stream_count(int'(mode), PIN_LG));
  end

  assign tx_fetch = slot_start;
  assign tx_slot  = SLOT_W'(slot_of(int'(pos), shv));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sr_q[g]   <= '0;
        tx_pin[g] <= 1'b0;
        tx_oe[g]  <= 1'b0;
      end else begin
        tx_oe[g] <= go && live[g];
        if (slot_start) begin
          tx_pin[g] <= tx_data[g*8+7];
          sr_q[g]   <= tx_data[g*8 +: 7];
        end else if (bit_start) begin
          tx_pin[g] <= sr_q[g][6];
          sr_q[g]   <= {sr_q[g][5:0], 1'b0};
        end
      end
    end
  end

  // R8: MSB of the fetched lane-0 byte leads the slot
  a_r8_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fetch |=> (tx_pin[0] == $past(tx_data[7])));
  // R9: enabled pins form a contiguous run from pin 0
  a_r9_oe_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_oe + 1'b1) & tx_oe) == '0);
endmodule

// File: rtl/tdm_port_group.sv
`timescale 1ns/1ps
module tdm_port_group #(
  parameter int NUM_PINS    = 4,
  parameter int FRAME_SLOTS = 128,
  localparam int PIN_LG     = $clog2(NUM_PINS),
  localparam int MODE_W     = (PIN_LG < 1) ? 1 : $clog2(PIN_LG + 1),
  localparam int STRM_W     = (PIN_LG < 1) ? 1 : PIN_LG,
  localparam int SLOT_W     = $clog2(FRAME_SLOTS),
  localparam int FRAME_CLKS = FRAME_SLOTS * 8,
  localparam int POS_W      = $clog2(FRAME_CLKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [MODE_W-1:0]     rx_mode,
  input  logic [MODE_W-1:0]     tx_mode,
  input  logic [NUM_PINS-1:0]   rx_pin,
  output logic                  rx_valid,
  output logic [7:0]            rx_byte,
  output logic [STRM_W-1:0]     rx_stream,
  output logic [SLOT_W-1:0]     rx_slot,
  output logic                  tx_fetch,
  output logic [SLOT_W-1:0]     tx_slot,
  input  logic [NUM_PINS*8-1:0] tx_data,
  output logic [NUM_PINS-1:0]   tx_pin,
  output logic [NUM_PINS-1:0]   tx_oe
);
  logic [POS_W-1:0]  pos;
  logic              go;
  logic [MODE_W-1:0] rx_mode_act;
  logic [MODE_W-1:0] tx_mode_act;

  tdm_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pos(pos), .go(go));

  tdm_mode_latch #(.MODE_W(MODE_W)) u_rx_mode (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .mode_in(rx_mode), .mode_act(rx_mode_act));

  tdm_mode_latch #(.MODE_W(MODE_W)) u_tx_mode (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .mode_in(tx_mode), .mode_act(tx_mode_act));

  tdm_rx_path #(
    .NUM_PINS(NUM_PINS), .POS_W(POS_W), .SLOT_W(SLOT_W),
    .STRM_W(STRM_W), .MODE_W(MODE_W), .PIN_LG(PIN_LG)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .go(go), .pos(pos), .mode(rx_mode_act),
    .rx_pin(rx_pin), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_stream(rx_stream), .rx_slot(rx_slot));

  tdm_tx_path #(
    .NUM_PINS(NUM_PINS), .POS_W(POS_W), .SLOT_W(SLOT_W),
    .MODE_W(MODE_W), .PIN_LG(PIN_LG)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .pos(pos), .mode(tx_mode_act),
    .tx_data(tx_data), .tx_fetch(tx_fetch), .tx_slot(tx_slot),
    .tx_pin(tx_pin), .tx_oe(tx_oe));

  // R10: nothing moves before the first strobe
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> (!rx_valid && !tx_fetch));
endmodule

// File: tb/tdm_port_group_test.sv
`timescale 1ns/1ps
module tdm_port_group_test;
  localparam int NP = 4;
  localparam int FC = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic [1:0]  rx_mode, tx_mode;
  logic [3:0]  rx_pin;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic [1:0]  rx_stream;
  logic [6:0]  rx_slot;
  logic        tx_fetch;
  logic [6:0]  tx_slot;
  logic [31:0] tx_data;
  logic [3:0]  tx_pin, tx_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int prev_rm, prev_tm;
  bit have_prev = 0;

  always #10 clk = ~clk;

  tdm_port_group uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .rx_mode(rx_mode), .tx_mode(tx_mode), .rx_pin(rx_pin),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_stream(rx_stream),
    .rx_slot(rx_slot), .tx_fetch(tx_fetch), .tx_slot(tx_slot),
    .tx_data(tx_data), .tx_pin(tx_pin), .tx_oe(tx_oe));

  function automatic logic [7:0] rx_pat(int s, int slot);
    return 8'(((slot * 29) + (s * 71) + 91) ^ (slot >> 2));
  endfunction

  function automatic logic [7:0] tx_pat(int s, int slot);
    return 8'((slot * 13) + (s * 97) + 195);
  endfunction

  // clocks-per-bit exponent restated from the layout table of R2
  function automatic int cpb_lg(int mode);
    case (mode)
      0:       return 2;
      1:       return 1;
      default: return 0;
    endcase
  endfunction

  always_comb
    for (int i = 0; i < NP; i++) tx_data[i*8 +: 8] = tx_pat(i, int'(tx_slot));

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frame_start = 1'b0; rx_mode = 2'd0; tx_mode = 2'd0; rx_pin = 4'hF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      #1;
      check(!rx_valid, "R10 rx_valid idle", rx_valid, 0);
      check(!tx_fetch, "R10 tx_fetch idle", tx_fetch, 0);
      check(tx_oe == 4'h0, "R10 tx_oe idle", tx_oe, 0);
    end
  endtask

  // rm/tm_in: mode pins driven at position 0; rm/tm_act: layout expected to govern
  task automatic run_frame(int rm_in, int tm_in, int rm_act, int tm_act,
                           bit pulse, bit mid_change);
    for (int p = 0; p < FC; p++) begin
      int sh, n, q, tm, k, sl;
      bit ev;
      int es, eslot;
      logic [7:0] eb;
      @(negedge clk);
      frame_start = pulse && (p == 0);
      if (p == 0) begin rx_mode = 2'(rm_in); tx_mode = 2'(tm_in); end
      if (mid_change && p == FC / 2) begin          // R6: ignored mid-frame
        rx_mode = 2'(rm_in ^ 1); tx_mode = 2'(tm_in ^ 2);
      end
      sh = cpb_lg(rm_act);
      n  = 1 << sh;
      for (int i = 0; i < NP; i++) begin
        if (i < n) rx_pin[i] = rx_pat(i, p >> (sh + 3))[7 - ((p >> sh) & 7)];
        else       rx_pin[i] = ((p * 7 + i * 3) % 5) < 2;   // R5: noise on dead pins
      end
      #1;
      // receive hand-out, R3 R4 R11
      ev = 0; es = 0; eslot = 0; eb = '0;
      for (int j = 0; j < NP; j++) begin
        int c, m, s2;
        bit src;
        c = p - 1 - j; m = rm_act; src = 1;
        if (c < 0) begin c += FC; m = prev_rm; src = have_prev; end
        s2 = cpb_lg(m);
        if (src && j < (1 << s2) && ((c + 1) % (8 << s2)) == 0) begin
          ev = 1; es = j; eslot = (c + 1) / (8 << s2) - 1; eb = rx_pat(j, eslot);
        end
      end
      check(rx_valid == ev, "R4 rx_valid", rx_valid, ev);
      if (ev && rx_valid) begin
        check(rx_stream == 2'(es), "R4 rx_stream", rx_stream, es);
        check(rx_slot == 7'(eslot), "R4 rx_slot", rx_slot, eslot);
        check(rx_byte == eb, "R3 R5 rx_byte", rx_byte, eb);
      end
      // transmit fetch, R7
      sh = cpb_lg(tm_act);
      ev = (p & ((8 << sh) - 1)) == 0;
      check(tx_fetch == ev, "R7 tx_fetch", tx_fetch, ev);
      if (ev) check(tx_slot == 7'(p >> (sh + 3)), "R7 tx_slot", tx_slot, p >> (sh + 3));
      // transmit pins lag one clock, R8 R9
      if (p >= 1 || have_prev) begin
        q  = (p >= 1) ? p - 1 : FC - 1;
        tm = (p >= 1) ? tm_act : prev_tm;
        sh = cpb_lg(tm);
        n  = 1 << sh;
        k  = (q >> sh) & 7;
        sl = q >> (sh + 3);
        for (int i = 0; i < NP; i++) begin
          check(tx_oe[i] == (i < n), "R9 tx_oe", tx_oe[i], i < n);
          if (i < n) check(tx_pin[i] == tx_pat(i, sl)[7 - k], "R8 tx_pin",
                           tx_pin[i], tx_pat(i, sl)[7 - k]);
        end
      end
    end
    prev_rm = rm_act; prev_tm = tm_act; have_prev = 1;
  endtask

  task automatic t_four_rx_one_tx();   run_frame(0, 2, 0, 2, 1, 0); endtask // R2
  task automatic t_two_rx_four_tx();   run_frame(1, 0, 1, 0, 1, 0); endtask // R11 R6
  task automatic t_one_rx_mid_change(); run_frame(2, 1, 2, 1, 1, 1); endtask // R6
  task automatic t_wrap_no_strobe();   run_frame(0, 0, 2, 1, 0, 0); endtask // R1 R6
  task automatic t_code3_clamp();      run_frame(3, 3, 2, 2, 1, 0); endtask // R2
  task automatic t_back_to_four();     run_frame(0, 1, 0, 1, 1, 0); endtask // R11

  initial begin
    t_reset();
    t_four_rx_one_tx();
    t_two_rx_four_tx();
    t_one_rx_mid_change();
    t_wrap_no_strobe();
    t_code3_clamp();
    t_back_to_four();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule